// File: doc/BRIEF.md
# I2S Burst-Clock Retimer

This block accepts a stereo serial audio stream whose bit clock arrives in short, irregular bursts, and turns it into a standard I2S stream with a free-running bit clock. On the input side, word select toggles once per channel. The bit clock for each word starts an unpredictable time after that toggle. The first rising edge of a burst carries the most significant bit. The block samples the three input pins with the 24.576 MHz system master clock and frames each word by counting burst edges. It stores the finished 16-bit word in a holding register for its channel.

On the output side, the master clock divided by eight gives a 3.072 MHz bit clock and 64 bit slots per frame, 32 for each channel. At the start of every output frame, both holding registers are copied into a frame buffer. The frame is then played out with the most significant bit one bit period after word select changes. An input frame that is complete within one output frame is therefore heard in the next output frame, so the delay is exactly one sample period. If a word is cut short, the channel keeps its previous sample and a sticky flag records the fault.

Top module: `i2s_retimer`

## Requirements
- R1: While reset is asserted and right after it, outBclk is 0, outWs is 1, outData is 0 and underrunErr is 0.
- R2: outBclk runs without gaps, with a period of 8 master-clock cycles: 4 cycles high and 4 cycles low. It has 128 rising edges in any 1024-cycle window.
- R3: outWs changes only as outBclk falls and holds each level for exactly 32 bit periods. Low marks the left channel and high marks the right channel.
- R4: outData changes only as outBclk falls. The 16 sample bits go out MSB first in bit slots 1 to 16 after each outWs change, where slot 0 is the period in which outWs changed. All other slots carry 0.
- R5: Each input word is framed by its own burst. The bit counter clears on every synchronized inWs edge, and data is shifted MSB first on the rising edges of inBclk. This works for any delay between the inWs edge and the first burst edge.
- R6: When a word gets more than 16 inBclk rising edges, the edges after the 16th are ignored and the stored sample is built from the first 16 bits.
- R7: Both channels are copied into the output at each left-channel frame start. A stereo input frame that finishes within one output frame appears in full in the next output frame, and the delay is the same for every frame.
- R8: A word with fewer than 16 inBclk edges before inWs toggles again leaves that channel's stored sample unchanged and sets underrunErr. This check applies only after the first complete word since reset. Complete words never set the flag.
- R9: Once set, underrunErr stays at 1 until reset, and reset clears it.
- R10: A word received while inWs is low goes to the left channel, and a word received while inWs is high goes to the right channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.576 MHz master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inBclk | input | 1 | Bursty input bit clock, asynchronous to clk |
| inWs | input | 1 | Input word select (0 = left, 1 = right) |
| inData | input | 1 | Input serial data, valid at inBclk rising edges |
| outBclk | output | 1 | Continuous output bit clock, clk / 8 |
| outWs | output | 1 | Output word select (0 = left, 1 = right) |
| outData | output | 1 | Output serial data, I2S format |
| underrunErr | output | 1 | Sticky flag for a short input word |

## Verification
The hardest case to reach is the fixed one-frame delay, because the input and output frame boundaries are unrelated. To force it, the stimulus waits for each output left-channel start and then sends a complete stereo input frame, with a varied delay before each burst. It queues the expected samples before the next output frame begins, so every stored frame must appear in exactly the next output frame. The short-word case is reached by stopping a left burst after ten edges. This shows the held left sample and the sticky flag in one frame, while the right word of that frame still updates.

// File: rtl/i2s_retimer_pkg.sv
package i2s_retimer_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned IDX_W  = $clog2(WORD_W);

  // strobes from control to datapath, valid for one clk cycle
  typedef struct packed {
    logic             shiftEn;     // take bitIn into the capture shifter
    logic             latchLeft;   // completed word goes to left hold
    logic             latchRight;  // completed word goes to right hold
    logic             bitIn;       // synchronized input data bit
    logic             snapFrame;   // copy both holds into the frame buffer
    logic             outTick;     // outBclk falls on this edge
    logic             outBitValid; // next slot carries a sample bit
    logic             outRight;    // next slot belongs to the right channel
    logic [IDX_W-1:0] outIdx;      // bit index of the sample for next slot
  } retimeStrobes_t;
endpackage

// File: rtl/i2s_retimer_ctrl.sv
module i2s_retimer_ctrl
  import i2s_retimer_pkg::*;
#(
  parameter int unsigned DIV   = 8,
  parameter int unsigned SLOTS = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inBclk,
  input  logic           inWs,
  input  logic           inData,
  output retimeStrobes_t strobes,
  output logic           outBclk,
  output logic           outWs,
  output logic           underrunErr
);
  localparam int unsigned HALF       = DIV / 2;
  localparam int unsigned DIV_W      = $clog2(DIV);
  localparam int unsigned SLOT_CNT_W = $clog2(2 * SLOTS);
  localparam int unsigned CNT_W      = $clog2(WORD_W + 1);

  // input synchronizers, third stage for edge detection
  logic [2:0] bclkPipe, wsPipe;
  logic [1:0] dataPipe;
  logic bclkRise, wsEdge, wsNow, wordDone;
  logic [CNT_W-1:0] bitCnt;
  logic armed, errR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkPipe <= '0;
      wsPipe   <= '0;
      dataPipe <= '0;
    end else begin
      bclkPipe <= {bclkPipe[1:0], inBclk};
      wsPipe   <= {wsPipe[1:0], inWs};
      dataPipe <= {dataPipe[0], inData};
    end
  end

  assign bclkRise = bclkPipe[1] & ~bclkPipe[2];
  assign wsEdge   = wsPipe[1] ^ wsPipe[2];
  assign wsNow    = wsPipe[1];

  // capture framing: counter restarts at every word-select edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      armed  <= 1'b0;
      errR   <= 1'b0;
    end else if (wsEdge) begin
      bitCnt <= '0;
      if (armed && bitCnt != CNT_W'(WORD_W)) errR <= 1'b1;
    end else if (bclkRise && bitCnt != CNT_W'(WORD_W)) begin
      bitCnt <= bitCnt + CNT_W'(1);
      if (bitCnt == CNT_W'(WORD_W - 1)) armed <= 1'b1;
    end
  end

  assign wordDone = strobes.shiftEn && bitCnt == CNT_W'(WORD_W - 1);

  // output timing: clock divider and slot counter
  logic [DIV_W-1:0]      divCnt, divNext;
  logic [SLOT_CNT_W-1:0] slot, slotNext;
  logic [SLOT_CNT_W-2:0] inner;
  logic tick, bclkR, wsR;

  assign tick     = divCnt == DIV_W'(DIV - 1);
  assign divNext  = tick ? '0 : divCnt + DIV_W'(1);
  assign slotNext = slot + SLOT_CNT_W'(1);
  assign inner    = slotNext[SLOT_CNT_W-2:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      slot   <= '1;
      bclkR  <= 1'b0;
      wsR    <= 1'b1;
    end else begin
      divCnt <= divNext;
      bclkR  <= divNext >= DIV_W'(HALF);
      if (tick) begin
        slot <= slotNext;
        wsR  <= slotNext[SLOT_CNT_W-1];
      end
    end
  end

  always_comb begin
    strobes             = '0;
    strobes.shiftEn     = bclkRise && !wsEdge && bitCnt != CNT_W'(WORD_W);
    strobes.latchLeft   = wordDone && !wsNow;
    strobes.latchRight  = wordDone && wsNow;
    strobes.bitIn       = dataPipe[1];
    strobes.outTick     = tick;
    strobes.snapFrame   = tick && slotNext == '0;
    strobes.outRight    = slotNext[SLOT_CNT_W-1];
    strobes.outBitValid = inner >= (SLOT_CNT_W-1)'(1) && inner <= (SLOT_CNT_W-1)'(WORD_W);
    if (strobes.outBitValid)
      strobes.outIdx = IDX_W'(int'(WORD_W) - int'(inner));
  end

  assign outBclk     = bclkR;
  assign outWs       = wsR;
  assign underrunErr = errR;
endmodule

// File: rtl/i2s_retimer_datapath.sv
module i2s_retimer_datapath
  import i2s_retimer_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  retimeStrobes_t strobes,
  output logic           outData
);
  logic [WORD_W-1:0] shiftReg, nextWord;
  logic [WORD_W-1:0] holdL, holdR, frameL, frameR;
  logic outDataR;

  assign nextWord = {shiftReg[WORD_W-2:0], strobes.bitIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      holdL    <= '0;
      holdR    <= '0;
      frameL   <= '0;
      frameR   <= '0;
      outDataR <= 1'b0;
    end else begin
      if (strobes.shiftEn)    shiftReg <= nextWord;
      if (strobes.latchLeft)  holdL    <= nextWord;
      if (strobes.latchRight) holdR    <= nextWord;
      if (strobes.snapFrame) begin
        frameL <= holdL;
        frameR <= holdR;
      end
      if (strobes.outTick) begin
        if (strobes.outBitValid)
          outDataR <= strobes.outRight ? frameR[strobes.outIdx] : frameL[strobes.outIdx];
        else
          outDataR <= 1'b0;
      end
    end
  end

  assign outData = outDataR;
endmodule

// File: rtl/i2s_retimer.sv
module i2s_retimer
  import i2s_retimer_pkg::*;
#(
  parameter int unsigned DIV   = 8,
  parameter int unsigned SLOTS = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic inBclk,
  input  logic inWs,
  input  logic inData,
  output logic outBclk,
  output logic outWs,
  output logic outData,
  output logic underrunErr
);
  retimeStrobes_t strobes;

  i2s_retimer_ctrl #(.DIV(DIV), .SLOTS(SLOTS)) ctrl_i (
    .clk(clk), .rstN(rstN), .inBclk(inBclk), .inWs(inWs), .inData(inData),
    .strobes(strobes), .outBclk(outBclk), .outWs(outWs), .underrunErr(underrunErr)
  );

  i2s_retimer_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .outData(outData)
  );
endmodule

// File: rtl/i2s_retimer_chk.sv
module i2s_retimer_chk #(
  parameter int unsigned DIV = 8
) (
  input logic clk,
  input logic rstN,
  input logic outBclk,
  input logic outWs,
  input logic outData,
  input logic underrunErr
);
  localparam int unsigned HALF  = DIV / 2;
  localparam int unsigned CNT_W = $clog2(DIV);

  logic prevBclk, seenEdge;
  logic [CNT_W-1:0] halfCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBclk <= 1'b0;
      seenEdge <= 1'b0;
      halfCnt  <= '0;
    end else begin
      prevBclk <= outBclk;
      if (outBclk != prevBclk) begin
        halfCnt  <= '0;
        seenEdge <= 1'b1;
      end else begin
        halfCnt <= halfCnt + CNT_W'(1);
      end
    end
  end

  p_half_period_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outBclk != prevBclk && seenEdge) |-> halfCnt == CNT_W'(HALF - 1));

  p_ws_on_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outWs) |-> $fell(outBclk));

  p_data_on_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outData) |-> $fell(outBclk));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    underrunErr |=> underrunErr);
endmodule

bind i2s_retimer i2s_retimer_chk #(.DIV(DIV)) chk_i (.*);

// File: tb/i2s_retimer_tb_top.sv
module i2s_retimer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inBclk = 1'b0;
  logic inWs = 1'b1;
  logic inData = 1'b0;
  logic outBclk, outWs, outData, underrunErr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] l;
    logic [15:0] r;
    string       tag;
  } frame_t;
  frame_t expQ[$];

  logic [15:0] modelL = '0;
  logic [15:0] modelR = '0;
  bit modelArmed = 1'b0;
  int riseCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_retimer dut_i (
    .clk(clk), .rstN(rstN), .inBclk(inBclk), .inWs(inWs), .inData(inData),
    .outBclk(outBclk), .outWs(outWs), .outData(outData), .underrunErr(underrunErr)
  );

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  // one word: word-select level, delay before burst, n burst edges
  task automatic sendWord(input logic ws, input logic [15:0] w, input int n, input int dly);
    inWs = ws;
    repeat (dly) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      inData = (i < 16) ? w[15 - i] : 1'b1;
      repeat (3) @(negedge clk);
      inBclk = 1'b1;
      repeat (3) @(negedge clk);
      inBclk = 1'b0;
    end
  endtask

  // driver: stereo frame aligned after an output frame start, expectation queued
  task automatic sendFrame(input logic [15:0] l, input logic [15:0] r, input int nL,
                           input int nR, input int dL, input int dR, input string tag);
    frame_t f;
    @(negedge outWs);
    repeat (6) @(negedge clk);
    sendWord(1'b0, l, nL, dL);
    sendWord(1'b1, r, nR, dR);
    repeat (8) @(negedge clk);
    if (nL >= 16) begin modelL = l; modelArmed = 1'b1; end
    if (nR >= 16) begin modelR = r; modelArmed = 1'b1; end
    f.l = modelL; f.r = modelR; f.tag = tag;
    expQ.push_back(f);
  endtask

  // an output frame with no input: stored samples repeat
  task automatic idleFrame(input string tag);
    frame_t f;
    @(negedge outWs);
    f.l = modelL; f.r = modelR; f.tag = tag;
    expQ.push_back(f);
  endtask

  // monitor: decodes output frames and compares against the queue
  initial begin
    logic prevB = 1'b0;
    logic lastWs = 1'b1;
    int pos = 0;
    int sinceRise = 0;
    bit pending = 1'b0;
    bit padBad = 1'b0;
    bit halfBad = 1'b0;
    bit perBad = 1'b0;
    logic [15:0] word = '0;
    logic [15:0] capL = '0;
    frame_t e;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        prevB = 1'b0; lastWs = 1'b1; pos = 0; pending = 1'b0; sinceRise = 0;
      end else begin
        sinceRise++;
        if (outBclk && !prevB) begin
          riseCount++;
          if (pending && sinceRise != 8) perBad = 1'b1;
          sinceRise = 0;
          if (outWs != lastWs) begin
            if (pos != 31) halfBad = 1'b1;
            pos = 0;
          end else begin
            pos++;
          end
          lastWs = outWs;
          if (!outWs && pos == 0) begin
            pending = expQ.size() > 0;
            padBad = 1'b0; halfBad = 1'b0; perBad = 1'b0;
          end
          if (pos >= 1 && pos <= 16) word[16 - pos] = outData;
          else if (outData !== 1'b0) padBad = 1'b1;
          if (!outWs && pos == 16) capL = word;
          if (outWs && pos == 31 && pending) begin
            e = expQ.pop_front();
            checkEq({e.tag, " R10 left sample"}, {16'h0, capL}, {16'h0, e.l});
            checkEq({e.tag, " R10 right sample"}, {16'h0, word}, {16'h0, e.r});
            checkEq({e.tag, " R4 pad slots low"}, {31'h0, padBad}, 32'h0);
            checkEq({e.tag, " R3 half length"}, {31'h0, halfBad}, 32'h0);
            checkEq({e.tag, " R2 bit period"}, {31'h0, perBad}, 32'h0);
            pending = 1'b0;
          end
        end
        prevB = outBclk;
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finishRun();
    end
  end

  initial begin
    int startRises;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkEq("R1 outBclk in reset", {31'h0, outBclk}, 32'h0);
    checkEq("R1 outWs in reset", {31'h0, outWs}, 32'h1);
    checkEq("R1 outData in reset", {31'h0, outData}, 32'h0);
    checkEq("R1 underrunErr in reset", {31'h0, underrunErr}, 32'h0);
    rstN = 1'b1;

    // R2: continuous bit clock, 128 rises in 1024 cycles
    repeat (20) @(negedge clk);
    startRises = riseCount;
    repeat (1024) @(negedge clk);
    checkEq("R2 rises per 1024 cycles", riseCount - startRises, 128);

    // R5 / R7: various burst delays
    sendFrame(16'hA5C3, 16'h5A3C, 16, 16, 1, 1, "R5 short delay");
    sendFrame(16'h8001, 16'h7FFE, 16, 16, 40, 17, "R5 long delay");
    sendFrame(16'h1234, 16'hFEDC, 16, 16, 23, 3, "R7 back to back");
    idleFrame("R7 repeat while idle");
    checkEq("R8 no flag on full words", {31'h0, underrunErr}, 32'h0);

    // R6: extra edges ignored
    sendFrame(16'h0F0F, 16'hC001, 20, 19, 5, 9, "R6 extra edges");
    checkEq("R6 no flag on extra edges", {31'h0, underrunErr}, 32'h0);

    // R8: short left word keeps previous left, right updates
    sendFrame(16'hDEAD, 16'h4242, 10, 16, 7, 7, "R8 short left");
    checkEq("R8 flag after short word", {31'h0, underrunErr}, 32'h1);

    // R9: sticky across good frames
    sendFrame(16'hBEEF, 16'h0001, 16, 16, 2, 30, "R9 after error");
    checkEq("R9 flag stays set", {31'h0, underrunErr}, 32'h1);
    idleFrame("R9 idle after error");

    // drain
    while (expQ.size() > 0) @(negedge clk);
    repeat (10) @(negedge clk);

    // R9 / R1: reset clears the flag
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R9 flag cleared by reset", {31'h0, underrunErr}, 32'h0);
    checkEq("R1 outWs after reset", {31'h0, outWs}, 32'h1);
    checkEq("R1 outBclk after reset", {31'h0, outBclk}, 32'h0);
    done = 1'b1;
    finishRun();
  end
endmodule